// File: doc/BRIEF.md
# Four-Code Cycling State Counter

A 3-bit state register that walks a fixed, non-binary ring of four codes, 000, 011, 101 and 010 and back to 000, taking one step on each rising clock edge while its step enable is high. The next-state logic comes in two forms chosen at elaboration time. The toggle form computes a per-bit toggle mask. The data form computes the next code directly. Both forms are minimised from the same transition table, with the four codes outside the ring left as don't-cares. The two forms agree on every code in the ring but part ways on the others. From an unused code the toggle form circles among the unused codes and never returns to the ring. The data form falls back into the ring within two steps.

A combinational flag marks any unused code held in the register. Reset is synchronous and active low. It loads a code set by a parameter, normally 000. That same parameter lets an instance start from an unused code, so each form's recovery behaviour can be seen without a run-time load port.

Top module: `seq_cycle_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state after that edge equals the parameter `RESET_CODE` (default 000), whatever `step_en` is.
- R2: With `step_en` high, each rising edge moves the state 000→011→101→010→000, bits written [2:0].
- R3: With `step_en` low, the state keeps its value across the edge.
- R4: `illegal` is high in the same cycle for the codes 001, 100, 110 and 111, and low for 000, 011, 101 and 010.
- R5: With `USE_TOGGLE`=1, the unused codes step 001→110→100→111→001, and the state never comes back to one of the ring codes.
- R6: With `USE_TOGGLE`=0, the unused codes step 001→011, 110→000, 100→010 and 111→100→010, so the ring is reached within two steps.
- R7: Starting from a ring code, both settings of `USE_TOGGLE` give the same sequence for the same `step_en` pattern.
- R8: A `RESET_CODE` set to an unused code is the state after reset, so it serves as a start point for R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance enable; low holds the state |
| state_q | output | 3 | Current state code |
| illegal | output | 1 | High while the state is an unused code |

## Verification
A new state is due one rising edge after the cycle in which `step_en` is driven. The illegal flag follows that state within the same cycle. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each step is checked exactly one register stage after its stimulus. Reset values are read on the falling edge that follows the first rising edge with `rst_n` low. Separate instances seeded with each unused code, in both forms, are stepped one edge at a time, and the state is compared after every edge.

// File: rtl/seq_cycle_pkg.sv
// Package: shared state type, ring codes and a legality test for the
// four-code cycling counter. Assumes a 3-bit state.
package seq_cycle_pkg;
    localparam int STATE_W = 3;
    typedef logic [STATE_W-1:0] code_t;

    localparam code_t RING_0 = 3'b000;
    localparam code_t RING_1 = 3'b011;
    localparam code_t RING_2 = 3'b101;
    localparam code_t RING_3 = 3'b010;

    // True when the code is one of the four ring members.
    function automatic logic on_ring(input code_t c);
        return (c == RING_0) || (c == RING_1) || (c == RING_2) || (c == RING_3);
    endfunction
endpackage

// File: rtl/seq_toggle_next.sv
// Toggle-form next-state logic: builds a per-bit toggle mask from the
// current code and applies it. Assumes unused codes were don't-cares.
module seq_toggle_next
    import seq_cycle_pkg::*;
(
    input  code_t cur,
    output code_t nxt
);
    code_t flip;

    // Toggle mask: top bit follows bit 0, middle always, low bit on !bit1.
    always_comb begin
        flip[2] = cur[0];
        flip[1] = 1'b1;
        flip[0] = ~cur[1];
        nxt     = cur ^ flip;
    end
endmodule

// File: rtl/seq_data_next.sv
// Data-form next-state logic: computes the next code directly from the
// current one. Assumes unused codes were don't-cares.
module seq_data_next
    import seq_cycle_pkg::*;
(
    input  code_t cur,
    output code_t nxt
);
    // Direct sum-of-products for each bit of the next code.
    always_comb begin
        nxt[2] = cur[1] & cur[0];
        nxt[1] = ~cur[1];
        nxt[0] = (~cur[2] & ~cur[1]) | (~cur[2] & cur[0]);
    end
endmodule

// File: rtl/seq_state_reg.sv
// State register with synchronous active-low reset to a parameter code
// and a load enable. Assumes a single clock domain.
module seq_state_reg
    import seq_cycle_pkg::*;
#(
    parameter logic [STATE_W-1:0] INIT = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  code_t d,
    output code_t q
);
    // Capture the next code on enable; reset wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= INIT;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/seq_cycle_counter.sv
// Top: four-code cycling counter. USE_TOGGLE picks toggle-form (1) or
// data-form (0) next-state logic; RESET_CODE is the code loaded by reset.
// Assumes step_en is synchronous to clk.
module seq_cycle_counter
    import seq_cycle_pkg::*;
#(
    parameter bit                 USE_TOGGLE = 1'b0,
    parameter logic [STATE_W-1:0] RESET_CODE = 3'b000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    output logic [STATE_W-1:0] state_q,
    output logic               illegal
);
    code_t cur_code;
    code_t next_code;

    generate
        if (USE_TOGGLE) begin : g_toggle
            seq_toggle_next u_next (.cur(cur_code), .nxt(next_code));
        end else begin : g_data
            seq_data_next u_next (.cur(cur_code), .nxt(next_code));
        end
    endgenerate

    seq_state_reg #(.INIT(RESET_CODE)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (step_en),
        .d     (next_code),
        .q     (cur_code)
    );

    // Drive outputs: state and the off-ring flag.
    always_comb begin
        state_q = cur_code;
        illegal = ~on_ring(cur_code);
    end
endmodule

// File: rtl/seq_cycle_counter_chk.sv
// Checker bound to seq_cycle_counter: relates state, enable and the
// off-ring flag across clock edges.
module seq_cycle_counter_chk #(
    parameter bit         USE_TOGGLE = 1'b0,
    parameter logic [2:0] RESET_CODE = 3'b000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       step_en,
    input logic [2:0] state_q,
    input logic       illegal
);
    AST_RESET_LOAD: assert property (@(posedge clk) !rst_n |=> state_q == RESET_CODE); // R1
    AST_STEP_A: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && state_q == 3'b000) |=> state_q == 3'b011); // R2
    AST_STEP_D: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && state_q == 3'b010) |=> state_q == 3'b000); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(state_q)); // R3
    AST_RING_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal |=> !illegal); // R7

    generate
        if (USE_TOGGLE) begin : g_tog
            AST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
                illegal |=> illegal); // R5
        end else begin : g_dat
            AST_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
                (illegal && step_en && state_q != 3'b111) |=> !illegal); // R6
        end
    endgenerate
endmodule

bind seq_cycle_counter seq_cycle_counter_chk #(
    .USE_TOGGLE (USE_TOGGLE),
    .RESET_CODE (RESET_CODE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .state_q (state_q),
    .illegal (illegal)
);

// File: tb/sim_seq_cycle_counter.sv
module sim_seq_cycle_counter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    logic [2:0] s0, s1, s2, s3, s4, s5, s6;
    logic       f0, f1, f2, f3, f4, f5, f6;

    seq_cycle_counter #(.USE_TOGGLE(1'b0), .RESET_CODE(3'b000)) u0 (.clk(clk), .rst_n(rst_n), .step_en(en), .state_q(s0), .illegal(f0));
    seq_cycle_counter #(.USE_TOGGLE(1'b1), .RESET_CODE(3'b000)) u1 (.clk(clk), .rst_n(rst_n), .step_en(en), .state_q(s1), .illegal(f1));
    seq_cycle_counter #(.USE_TOGGLE(1'b1), .RESET_CODE(3'b001)) u2 (.clk(clk), .rst_n(rst_n), .step_en(en), .state_q(s2), .illegal(f2));
    seq_cycle_counter #(.USE_TOGGLE(1'b0), .RESET_CODE(3'b001)) u3 (.clk(clk), .rst_n(rst_n), .step_en(en), .state_q(s3), .illegal(f3));
    seq_cycle_counter #(.USE_TOGGLE(1'b0), .RESET_CODE(3'b110)) u4 (.clk(clk), .rst_n(rst_n), .step_en(en), .state_q(s4), .illegal(f4));
    seq_cycle_counter #(.USE_TOGGLE(1'b0), .RESET_CODE(3'b100)) u5 (.clk(clk), .rst_n(rst_n), .step_en(en), .state_q(s5), .illegal(f5));
    seq_cycle_counter #(.USE_TOGGLE(1'b0), .RESET_CODE(3'b111)) u6 (.clk(clk), .rst_n(rst_n), .step_en(en), .state_q(s6), .illegal(f6));

    // Vector table: {step_en, expected state after the edge} from 000.
    localparam int NVEC = 10;
    localparam logic [3:0] VEC [NVEC] = '{
        4'b1_011, 4'b1_101, 4'b0_101, 4'b1_010, 4'b1_000,
        4'b1_011, 4'b0_011, 4'b0_011, 4'b1_101, 4'b1_010
    };
    // Toggle-form orbit of unused codes after 001.
    localparam logic [2:0] ORBIT [4] = '{3'b110, 3'b100, 3'b111, 3'b001};

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic e);
        en = e;
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        en = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic off_ring(input logic [2:0] c);
        return !(c == 3'b000 || c == 3'b011 || c == 3'b101 || c == 3'b010);
    endfunction

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 u0 reset", {1'b0, s0}, 4'b0000);
        chk("R1 u1 reset", {1'b0, s1}, 4'b0000);
        chk("R4 flag at 000", {3'b0, f0}, 4'b0000);
        chk("R8 u2 seed", {1'b0, s2}, 4'b0001);
        chk("R8 u6 seed", {1'b0, s6}, 4'b0111);
        chk("R4 flag at 001", {3'b0, f2}, 4'b0001);
        chk("R4 flag at 110", {3'b0, f4}, 4'b0001);
        chk("R4 flag at 100", {3'b0, f5}, 4'b0001);
        chk("R4 flag at 111", {3'b0, f6}, 4'b0001);
        rst_n = 1'b1;
        step(1'b0);
        chk("R3 hold u2", {1'b0, s2}, 4'b0001);
        step(1'b1);
        chk("R6 001 to 011", {1'b0, s3}, 4'b0011);
        chk("R6 110 to 000", {1'b0, s4}, 4'b0000);
        chk("R6 100 to 010", {1'b0, s5}, 4'b0010);
        chk("R6 111 to 100", {1'b0, s6}, 4'b0100);
        chk("R4 flag clear after recovery", {3'b0, f3}, 4'b0000);
        chk("R5 001 to 110", {1'b0, s2}, 4'b0110);
        step(1'b1);
        chk("R6 111 then 010", {1'b0, s6}, 4'b0010);
        chk("R4 flag 100 then clear", {3'b0, f6}, 4'b0000);
        for (int i = 1; i < 9; i++) begin
            if (i > 1) step(1'b1);
            chk("R5 toggle orbit", {1'b0, s2}, {1'b0, ORBIT[i % 4]});
            chk("R5 never on ring", {3'b0, off_ring(s2)}, 4'b0001);
        end

        do_reset();
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][3]);
            chk("R2/R3 data form", {1'b0, s0}, {1'b0, VEC[i][2:0]});
            chk("R7 toggle form matches", {1'b0, s1}, {1'b0, VEC[i][2:0]});
            chk("R4 flag low on ring", {3'b0, f1}, 4'b0000);
        end

        // R1: reset mid-run with enable high.
        rst_n = 1'b0;
        en = 1'b1;
        @(negedge clk);
        chk("R1 mid-run reset", {1'b0, s0}, 4'b0000);
        rst_n = 1'b1;
        step(1'b1);
        chk("R2 first step after reset", {1'b0, s0}, 4'b0011);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule